// File: doc/BRIEF.md
# Limit-Match Counter-Timer

This block is a counter-timer attached to a 32-bit word register port. A tick input pulses once per 500 ns step. On each tick the count advances by one unit, where one unit is bit 9 of the register value, so the count is 31 bits wide with bits 8:0 always zero. When a programmed limit is reached, the block sets a reached flag and raises a level interrupt, and the count starts again from zero. A limit of zero turns the block into a free-running counter that never matches.

Software programs the limit in one of two ways. The first write address restarts the count. The second write address leaves the running count alone. Reading the limit back acknowledges the event and clears both the flag and the interrupt. The register port is a plain single-cycle strobe port with no back-pressure. Every write and read is taken in the cycle its enable is high. Read data is combinational on the address and reflects the state before that cycle's clock edge. Any side effect of a read takes effect at that edge.

Top module: `limit_timer`

## Requirements
- R1: After reset the limit is zero, the count is zero, the reached flag is clear and `irq` is low. The counter then runs free.
- R2: Each cycle with `tick` high adds 0x200 to the count value. Without a tick the count holds. Bits 8:0 of a count read are always zero.
- R3: The register index is `reg_addr >> 2`. Reading index 0 returns the limit with bit 31 zero. Reading index 1 returns the reached flag in bit 31 and the count in bits 30:9. Reading any other index returns zero. Writes to index 1 or to indices 3 to 7 change nothing.
- R4: A write to index 0 stores `reg_wdata & 0x7FFFFE00` as the limit, sets the count to zero and drives `irq` low from the next cycle. A tick in the same cycle is dropped. The reached flag is left as it was.
- R5: With a nonzero limit L, the count runs 0, 0x200, and so on up to L-0x200. The next tick sets the count to zero and sets both the reached flag and `irq`, which gives a period of L/512 ticks.
- R6: `irq` is a level output. It stays high until index 0 is read or written. A further match while it is high changes nothing else.
- R7: A read of index 0 clears the reached flag and `irq`. If a match happens in the same cycle, the match wins and both end up set.
- R8: With a limit of zero, the count runs up to 0x7FFFFE00 and then wraps to zero. The reached flag and `irq` are never set.
- R9: A write to index 2 stores the masked limit and leaves the count unchanged. Counting then goes on against the new limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per 500 ns count step |
| reg_wr_en | input | 1 | Write strobe |
| reg_rd_en | input | 1 | Read strobe; a read of index 0 acknowledges the event |
| reg_addr | input | 5 | Byte address; the word index is bits 4:2 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt on limit match |

## Verification
The checker watches every cycle for the following. The count steps exactly once per accepted tick and holds otherwise. A restart write zeroes the count and drops `irq`. `irq` only rises on a match. No match ever happens while the limit is zero. An acknowledge read clears the flags unless a match happens in the same cycle. Only the directed scenarios can show the things that depend on sequences seen at the register port: the exact match period, the limit masking, the read-back layout, the writes that are ignored, and the fact that an index-2 write really leaves the count running against the new limit.

// File: rtl/lmt_pkg.sv
package lmt_pkg;
  // word indices of the register map
  localparam int IDX_LIMIT      = 0;
  localparam int IDX_COUNT      = 1;
  localparam int IDX_LIMIT_KEEP = 2;
endpackage

// File: rtl/lmt_decode.sv
module lmt_decode #(
  parameter int ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_lim,
  output logic              wr_keep,
  output logic              rd_ack,
  output logic              sel_lim,
  output logic              sel_cnt
);
  import lmt_pkg::*;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             unused_lsb;

  assign idx        = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    sel_lim = (idx == IDX_W'(IDX_LIMIT));
    sel_cnt = (idx == IDX_W'(IDX_COUNT));
    wr_lim  = wr_en && sel_lim;
    wr_keep = wr_en && (idx == IDX_W'(IDX_LIMIT_KEEP));
    rd_ack  = rd_en && sel_lim;
  end
endmodule

// File: rtl/lmt_count.sv
module lmt_count #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             lim_load,
  input  logic [CNT_W-1:0] lim_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] lim_q,
  output logic             match
);
  logic [CNT_W-1:0] cnt_next;
  logic             step;

  assign step     = tick && !restart;
  assign cnt_next = cnt_q + CNT_W'(1);
  // a zero limit never compares equal: free-run wraps through all ones
  assign match    = step && (lim_q != '0) && (cnt_next == lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= match ? '0 : cnt_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lim_q <= '0;
    else if (lim_load) lim_q <= lim_in;
  end
endmodule

// File: rtl/lmt_flags.sv
module lmt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ack_rd,
  input  logic ack_wr,
  output logic reached,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reached <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (hit)         reached <= 1'b1;
      else if (ack_rd) reached <= 1'b0;
      if (hit)                   irq <= 1'b1;
      else if (ack_rd || ack_wr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/limit_timer.sv
module limit_timer #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 9,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CNT_W = DATA_W - 1 - FRAC_W;

  logic             wr_lim, wr_keep, rd_ack, sel_lim, sel_cnt;
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic             match, reached;
  logic             unused_wd;

  assign unused_wd = ^{reg_wdata[DATA_W-1], reg_wdata[FRAC_W-1:0]};

  lmt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (reg_wr_en),
    .rd_en   (reg_rd_en),
    .addr    (reg_addr),
    .wr_lim  (wr_lim),
    .wr_keep (wr_keep),
    .rd_ack  (rd_ack),
    .sel_lim (sel_lim),
    .sel_cnt (sel_cnt)
  );

  lmt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .restart  (wr_lim),
    .lim_load (wr_lim || wr_keep),
    .lim_in   (reg_wdata[DATA_W-2:FRAC_W]),
    .cnt_q    (cnt_q),
    .lim_q    (lim_q),
    .match    (match)
  );

  lmt_flags u_flg (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (match),
    .ack_rd  (rd_ack),
    .ack_wr  (wr_lim),
    .reached (reached),
    .irq     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_lim)      reg_rdata = {1'b0, lim_q, {FRAC_W{1'b0}}};
    else if (sel_cnt) reg_rdata = {reached, cnt_q, {FRAC_W{1'b0}}};
  end
endmodule

// File: rtl/lmt_chk.sv
module lmt_chk #(
  parameter int CNT_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_lim,
  input logic             rd_ack,
  input logic             match,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] lim_q,
  input logic             reached,
  input logic             irq
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_lim && !match) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_lim) |=> $stable(cnt_q)); // R2
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim |=> (cnt_q == '0 && !irq)); // R4
  AST_IRQ_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(match)); // R6
  AST_MATCH_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt_q == '0 && irq && reached)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !match) |=> (!reached && !irq)); // R7
  AST_FREE_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == '0) |-> !match); // R8
endmodule

bind limit_timer lmt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_lim(wr_lim), .rd_ack(rd_ack),
  .match(match), .cnt_q(cnt_q), .lim_q(lim_q), .reached(reached), .irq(irq)
);

// File: tb/tb_limit_timer.sv
module tb_limit_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  limit_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 5'(idx << 2); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // read sampled before the edge that applies any side effect
  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = 5'(idx << 2);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq after reset", 32'(irq), 32'd0);
    rd(1, d); check("R1 count after reset", d, 32'h0);
    rd(0, d); check("R1 limit after reset", d, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    ticks(5);
    rd(1, d); check("R2 count after 5 ticks", d, 32'h0000_0A00);
    repeat (3) @(negedge clk);
    rd(1, d); check("R2 count holds without tick", d, 32'h0000_0A00);
    check("R8 no irq in free run", 32'(irq), 32'd0);
  endtask

  task automatic t_match();
    logic [31:0] d;
    wr(0, 32'h8000_0BFF);
    rd(1, d); check("R4 restart on limit write", d, 32'h0);
    ticks(4);
    rd(1, d); check("R5 count before match", d, 32'h0000_0800);
    check("R5 irq low before match", 32'(irq), 32'd0);
    ticks(1);
    check("R5 irq on match", 32'(irq), 32'd1);
    rd(1, d); check("R5 reached and wrap", d, 32'h8000_0000);
    ticks(5);
    check("R6 irq stays high", 32'(irq), 32'd1);
    rd(1, d); check("R6 second match", d, 32'h8000_0000);
    rd(0, d); check("R3 limit readback masked", d, 32'h0000_0A00);
    check("R7 irq cleared by limit read", 32'(irq), 32'd0);
    rd(1, d); check("R7 reached cleared", d, 32'h0);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    ticks(2);
    wr(1, 32'h1234_5600);
    rd(1, d); check("R3 write to count index ignored", d, 32'h0000_0400);
    wr(3, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    rd(3, d); check("R3 index 3 reads zero", d, 32'h0);
    rd(4, d); check("R3 index 4 reads zero", d, 32'h0);
    rd(7, d); check("R3 index 7 reads zero", d, 32'h0);
    rd(1, d); check("R3 count after ignored writes", d, 32'h0000_0400);
    rd(0, d); check("R3 limit after ignored writes", d, 32'h0000_0A00);
  endtask

  task automatic t_keep();
    logic [31:0] d;
    wr(2, 32'h0000_1000);
    rd(1, d); check("R9 count kept", d, 32'h0000_0400);
    rd(0, d); check("R9 new limit", d, 32'h0000_1000);
    ticks(5);
    rd(1, d); check("R9 old limit passed", d, 32'h0000_0E00);
    check("R9 no irq at old limit", 32'(irq), 32'd0);
    ticks(1);
    check("R9 irq at new limit", 32'(irq), 32'd1);
  endtask

  task automatic t_wr_ack();
    logic [31:0] d;
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 5'd0; reg_wdata = 32'h0000_0600; tick = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; tick = 1'b0;
    check("R4 irq dropped by limit write", 32'(irq), 32'd0);
    rd(1, d); check("R4 tick dropped, reached kept", d, 32'h8000_0000);
    rd(0, d); check("R4 limit written", d, 32'h0000_0600);
  endtask

  task automatic t_race();
    logic [31:0] d;
    ticks(2);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = 5'd0; tick = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0; tick = 1'b0;
    check("R7 match wins over ack irq", 32'(irq), 32'd1);
    rd(1, d); check("R7 match wins over ack flag", d, 32'h8000_0000);
  endtask

  task automatic t_free();
    logic [31:0] d;
    rd(0, d);
    wr(0, 32'h0000_01FF);
    ticks(300);
    check("R8 free run no irq", 32'(irq), 32'd0);
    rd(1, d); check("R8 free run count", d, 32'(300 * 512));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_match();
    t_ignore();
    t_keep();
    t_wr_ack();
    t_race();
    t_free();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule